// File: doc/BRIEF.md
# Laser Transmit Safety Controller

This controller sits on the module side of a pluggable optical transmitter. It decides when the laser may emit and raises a transmit-fault flag towards the host. It watches three inputs: a supply-good indication, the host's transmit-disable line and the raw output of a fault detector. From these it derives the laser enable, the fault flag and a busy indication that covers each initialisation window.

After the supply becomes good, the controller runs an initialisation window. At the end of that window it samples the fault detector once and then enters normal transmission, a host-disabled hold, or a latched fault. A latched fault keeps the laser dark even after the detector goes quiet. The host can clear it only by holding the disable line high for a minimum time and then releasing it. The controller then repeats the initialisation window with the fault flag still raised. If the fault has gone by the end of that window, the flag drops. If the fault is still there, the fault latches again.

All windows are counted in ticks of an internal clock-enable. A prescaler derives the tick from the clock and restarts whenever a window starts. With the default parameters at a 50 MHz clock, a tick is 1 µs, the initialisation window is 300 ms and the minimum reset pulse is 10 µs.

Top module: `laser_safety_ctrl`

## Requirements
- R1: While rst_n is low, and in the powered-off state it selects, laser_en, tx_fault and init_busy are all 0.
- R2: One cycle after vcc_good is seen high in the powered-off state, init_busy goes to 1 and stays at 1 for exactly INIT_TICKS*TICK_DIV+1 cycles.
- R3: When the initialisation window ends with fault_detect and tx_disable both low, laser_en becomes 1 in the cycle after init_busy drops, and tx_fault stays 0.
- R4: fault_detect is sampled only in the last cycle of the initialisation window. A pulse earlier in the window has no effect. A high level in the last cycle sets tx_fault=1 with laser_en=0.
- R5: In normal transmission, tx_disable high drops laser_en one cycle later. tx_disable low again with no latched fault restores laser_en one cycle later.
- R6: fault_detect high during normal transmission or the disabled hold sets tx_fault=1 and laser_en=0 one cycle later. Both stay that way after fault_detect returns low.
- R7: While a fault is latched, a tx_disable high pulse shorter than RST_TICKS*TICK_DIV cycles is ignored. tx_fault stays 1, laser_en stays 0 and init_busy stays 0.
- R8: While a fault is latched, a tx_disable high pulse of at least RST_TICKS*TICK_DIV cycles starts a re-initialisation one cycle after tx_disable falls. init_busy=1, tx_fault stays 1 and laser_en=0 throughout the window, which is the same length as in R2.
- R9: A re-initialisation that ends with fault_detect low clears tx_fault. laser_en becomes 1 if tx_disable is low.
- R10: A re-initialisation that ends with fault_detect high latches the fault again. tx_fault stays 1, laser_en stays 0 and init_busy drops.
- R11: vcc_good low in any state sends all three outputs to 0 one cycle later and discards any latched fault.
- R12: laser_en is never 1 in the cycle after one in which tx_disable or fault_detect was high or vcc_good was low. This includes an initialisation that ends with tx_disable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcc_good | input | 1 | Supply above its good threshold |
| tx_disable | input | 1 | Host transmit disable, high turns the laser off |
| fault_detect | input | 1 | Raw unsafe-condition detector output |
| laser_en | output | 1 | Enable to the laser driver |
| tx_fault | output | 1 | Transmit fault flag to the host, active high |
| init_busy | output | 1 | High during each initialisation window |

## Verification
The three outputs are decoded directly from the state register. A wrong state therefore shows at the ports in the very next cycle: the laser lit during a fault or hold, a fault flag with no cause, or a busy flag outside a window. A wrong window count shows up one cycle early or late on the falling edge of init_busy. A reset-pulse width that is measured wrongly shows up as a re-initialisation that should or should not have started, one cycle after tx_disable falls. A cycle-by-cycle behavioural model catches each of these in the cycle it happens, and directed checks probe the pulse width on both sides of the limit.

// File: rtl/laser_safety_pkg.sv
package laser_safety_pkg;

  typedef enum logic [2:0] {
    ST_POWER_OFF,
    ST_INIT,
    ST_RUN,
    ST_DISABLED,
    ST_FAULT,
    ST_REINIT
  } safeState_t;

  // strobes from control to the window timer
  typedef struct packed {
    logic clrTimer;
    logic countEn;
  } timerCmd_t;

  // conditions reported back by the window timer
  typedef struct packed {
    logic initDone;
    logic resetMet;
  } timerFlags_t;

endpackage

// File: rtl/laser_safety_timer.sv
module laser_safety_timer
  import laser_safety_pkg::*;
#(
  parameter int TICK_DIV   = 50,
  parameter int INIT_TICKS = 300000,
  parameter int RST_TICKS  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  timerCmd_t   cmd,
  output timerFlags_t flags
);

  localparam int MAX_TICKS = (INIT_TICKS > RST_TICKS) ? INIT_TICKS : RST_TICKS;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

  logic              tickEn;
  logic [TICK_W-1:0] tickCnt;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] preCnt;
      logic             preWrap;

      assign preWrap = (preCnt == PRE_W'(TICK_DIV - 1));

      always_ff @(posedge clk) begin
        if (!rst_n)            preCnt <= '0;
        else if (cmd.clrTimer) preCnt <= '0;
        else if (cmd.countEn)  preCnt <= preWrap ? '0 : preCnt + 1'b1;
      end

      assign tickEn = cmd.countEn && !cmd.clrTimer && preWrap;
    end else begin : g_nopre
      assign tickEn = cmd.countEn && !cmd.clrTimer;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                                   tickCnt <= '0;
    else if (cmd.clrTimer)                        tickCnt <= '0;
    else if (tickEn && tickCnt != TICK_W'(MAX_TICKS)) tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    flags.initDone = (tickCnt >= TICK_W'(INIT_TICKS));
    flags.resetMet = (tickCnt >= TICK_W'(RST_TICKS));
  end

  // R2: a freshly started window can never report completion on its first cycle
  a_r2_clear_restarts_window: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clrTimer |=> !flags.initDone);

  // R7: the pulse-width condition cannot be met right after a restart
  a_r7_clear_drops_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clrTimer |=> !flags.resetMet);

endmodule

// File: rtl/laser_safety_fsm.sv
module laser_safety_fsm
  import laser_safety_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vcc_good,
  input  logic        tx_disable,
  input  logic        fault_detect,
  input  timerFlags_t flags,
  output timerCmd_t   cmd,
  output logic        laser_en,
  output logic        tx_fault,
  output logic        init_busy
);

  safeState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_POWER_OFF;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    if (!vcc_good) begin
      nextState = ST_POWER_OFF;
    end else begin
      unique case (state)
        ST_POWER_OFF: nextState = ST_INIT;
        ST_INIT, ST_REINIT: begin
          if (flags.initDone) begin
            if (fault_detect)    nextState = ST_FAULT;
            else if (tx_disable) nextState = ST_DISABLED;
            else                 nextState = ST_RUN;
          end
        end
        ST_RUN: begin
          if (fault_detect)    nextState = ST_FAULT;
          else if (tx_disable) nextState = ST_DISABLED;
        end
        ST_DISABLED: begin
          if (fault_detect)     nextState = ST_FAULT;
          else if (!tx_disable) nextState = ST_RUN;
        end
        ST_FAULT: begin
          if (!tx_disable && flags.resetMet) nextState = ST_REINIT;
        end
        default: nextState = ST_POWER_OFF;
      endcase
    end
  end

  always_comb begin
    cmd.clrTimer = (nextState != state) || (state == ST_FAULT && !tx_disable);
    cmd.countEn  = (state == ST_INIT) || (state == ST_REINIT) || (state == ST_FAULT);
  end

  assign laser_en  = (state == ST_RUN);
  assign tx_fault  = (state == ST_FAULT) || (state == ST_REINIT);
  assign init_busy = (state == ST_INIT) || (state == ST_REINIT);

  // R12: light only follows a cycle with supply good and no disable or fault
  a_r12_light_needs_clear_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    laser_en |-> ($past(vcc_good) && !$past(tx_disable) && !$past(fault_detect)));

  // R11: supply loss darkens everything on the next cycle
  a_r11_supply_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_good |=> (!laser_en && !tx_fault && !init_busy));

  // R6: a detected fault while operating latches the flag and kills the laser
  a_r6_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN || state == ST_DISABLED) && vcc_good && fault_detect)
      |=> (tx_fault && !laser_en));

  // R7: a release before the pulse limit keeps the fault latched
  a_r7_short_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && vcc_good && !tx_disable && !flags.resetMet)
      |=> (tx_fault && !init_busy));

  // R10: a persisting fault at the end of re-initialisation latches again
  a_r10_fault_relatches: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REINIT && vcc_good && flags.initDone && fault_detect)
      |=> (tx_fault && !init_busy && !laser_en));

endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl
  import laser_safety_pkg::*;
#(
  parameter int TICK_DIV   = 50,
  parameter int INIT_TICKS = 300000,
  parameter int RST_TICKS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_good,
  input  logic tx_disable,
  input  logic fault_detect,
  output logic laser_en,
  output logic tx_fault,
  output logic init_busy
);

  timerCmd_t   timerCmd;
  timerFlags_t timerFlags;

  laser_safety_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_good     (vcc_good),
    .tx_disable   (tx_disable),
    .fault_detect (fault_detect),
    .flags        (timerFlags),
    .cmd          (timerCmd),
    .laser_en     (laser_en),
    .tx_fault     (tx_fault),
    .init_busy    (init_busy)
  );

  laser_safety_timer #(
    .TICK_DIV   (TICK_DIV),
    .INIT_TICKS (INIT_TICKS),
    .RST_TICKS  (RST_TICKS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (timerCmd),
    .flags (timerFlags)
  );

endmodule

// File: tb/laser_safety_ctrl_tb_top.sv
`timescale 1ns/1ps
module laser_safety_ctrl_tb_top;

  localparam int DIV    = 4;
  localparam int INIT_T = 6;
  localparam int RST_T  = 3;
  localparam int WIN    = INIT_T * DIV + 1;
  localparam int PULSE  = RST_T * DIV;

  localparam int M_OFF = 0, M_INIT = 1, M_RUN = 2, M_DIS = 3, M_FAULT = 4, M_REINIT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_good = 1'b0;
  logic tx_disable = 1'b0;
  logic fault_detect = 1'b0;
  logic laser_en, tx_fault, init_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  laser_safety_ctrl #(.TICK_DIV(DIV), .INIT_TICKS(INIT_T), .RST_TICKS(RST_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .vcc_good(vcc_good), .tx_disable(tx_disable),
    .fault_detect(fault_detect), .laser_en(laser_en), .tx_fault(tx_fault),
    .init_busy(init_busy)
  );

  // behavioural reference: a state code and a count of edges since the window began
  int mState = M_OFF;
  int mCyc = 0;

  always @(posedge clk) begin
    int nxt;
    if (!rst_n) begin
      mState = M_OFF;
      mCyc = 0;
    end else begin
      nxt = mState;
      if (!vcc_good) nxt = M_OFF;
      else if (mState == M_OFF) nxt = M_INIT;
      else if (mState == M_INIT || mState == M_REINIT) begin
        if (mCyc >= INIT_T * DIV)
          nxt = fault_detect ? M_FAULT : (tx_disable ? M_DIS : M_RUN);
      end else if (mState == M_RUN) begin
        if (fault_detect) nxt = M_FAULT;
        else if (tx_disable) nxt = M_DIS;
      end else if (mState == M_DIS) begin
        if (fault_detect) nxt = M_FAULT;
        else if (!tx_disable) nxt = M_RUN;
      end else if (mState == M_FAULT) begin
        if (!tx_disable && mCyc >= PULSE) nxt = M_REINIT;
      end
      if (nxt != mState || (mState == M_FAULT && !tx_disable)) mCyc = 0;
      else mCyc = mCyc + 1;
      mState = nxt;
    end
  end

  function automatic string tagOf(int s);
    case (s)
      M_OFF:    return "R11";
      M_INIT:   return "R2";
      M_RUN:    return "R3";
      M_DIS:    return "R5";
      M_FAULT:  return "R6";
      default:  return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!finished) begin
      chk(tagOf(mState), laser_en,  (mState == M_RUN), "model laser_en");
      chk(tagOf(mState), tx_fault,  (mState == M_FAULT || mState == M_REINIT), "model tx_fault");
      chk(tagOf(mState), init_busy, (mState == M_INIT || mState == M_REINIT), "model init_busy");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitWindow(output int len);
    len = 0;
    while (init_busy === 1'b1 && len < 1000) begin
      len++;
      cyc(1);
    end
  endtask

  task automatic faultPulse();
    fault_detect = 1'b1; cyc(1); fault_detect = 1'b0;
  endtask

  task automatic disablePulse(int hi);
    tx_disable = 1'b1; cyc(hi); tx_disable = 1'b0; cyc(1);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int len;
    cyc(3);
    chk("R1", laser_en, 1'b0, "reset laser_en");
    chk("R1", tx_fault, 1'b0, "reset tx_fault");
    chk("R1", init_busy, 1'b0, "reset init_busy");
    rst_n = 1'b1;
    cyc(3);
    chk("R1", laser_en | tx_fault | init_busy, 1'b0, "powered-off outputs");

    // power-up window
    vcc_good = 1'b1; cyc(1);
    chk("R2", init_busy, 1'b1, "busy after supply good");
    waitWindow(len);
    chk("R2", (len == WIN), 1'b1, "init window length");
    chk("R3", laser_en, 1'b1, "laser on after init");
    chk("R3", tx_fault, 1'b0, "no fault after init");

    // host disable
    tx_disable = 1'b1; cyc(1);
    chk("R5", laser_en, 1'b0, "disable drops laser");
    cyc(3);
    tx_disable = 1'b0; cyc(1);
    chk("R5", laser_en, 1'b1, "release restores laser");

    // fault latch
    faultPulse(); 
    chk("R6", tx_fault, 1'b1, "fault flag set");
    chk("R6", laser_en, 1'b0, "laser off on fault");
    cyc(5);
    chk("R6", tx_fault, 1'b1, "fault stays latched");

    // pulse one cycle short of the limit
    disablePulse(PULSE - 1);
    cyc(2);
    chk("R7", init_busy, 1'b0, "short pulse no reinit");
    chk("R7", tx_fault, 1'b1, "short pulse keeps fault");
    chk("R7", laser_en, 1'b0, "short pulse keeps laser off");

    // pulse exactly at the limit, fault gone
    tx_disable = 1'b1; cyc(PULSE); tx_disable = 1'b0; cyc(1);
    chk("R8", init_busy, 1'b1, "reinit starts");
    chk("R8", tx_fault, 1'b1, "flag held in reinit");
    chk("R8", laser_en, 1'b0, "laser off in reinit");
    waitWindow(len);
    chk("R8", (len == WIN), 1'b1, "reinit window length");
    chk("R9", tx_fault, 1'b0, "transient fault cleared");
    chk("R9", laser_en, 1'b1, "laser back after reinit");

    // persisting fault
    faultPulse();
    fault_detect = 1'b1;
    cyc(2);
    disablePulse(PULSE + 2);
    chk("R10", init_busy, 1'b1, "reinit with persisting fault");
    waitWindow(len);
    chk("R10", tx_fault, 1'b1, "fault relatched");
    chk("R10", laser_en, 1'b0, "laser stays off");
    fault_detect = 1'b0; cyc(3);
    chk("R10", tx_fault, 1'b1, "relatched fault holds");

    // supply loss clears the latch
    vcc_good = 1'b0; cyc(1);
    chk("R11", tx_fault | laser_en | init_busy, 1'b0, "supply loss outputs");
    cyc(2);

    // early fault pulse in the window is ignored
    vcc_good = 1'b1; cyc(2);
    faultPulse();
    cyc(3);
    waitWindow(len);
    chk("R4", laser_en, 1'b1, "early fault ignored");
    chk("R4", tx_fault, 1'b0, "early fault no flag");

    // fault present at the end of the window
    vcc_good = 1'b0; cyc(2);
    vcc_good = 1'b1; fault_detect = 1'b1; cyc(1);
    waitWindow(len);
    chk("R4", tx_fault, 1'b1, "end-of-window fault latched");
    chk("R4", laser_en, 1'b0, "end-of-window fault dark");
    fault_detect = 1'b0;

    // init ending with disable held high
    vcc_good = 1'b0; cyc(2);
    vcc_good = 1'b1; tx_disable = 1'b1; cyc(1);
    waitWindow(len);
    chk("R12", laser_en, 1'b0, "disabled at end of init");
    chk("R12", tx_fault, 1'b0, "no fault in hold");
    cyc(3);
    chk("R12", laser_en, 1'b0, "hold keeps laser dark");
    tx_disable = 1'b0; cyc(1);
    chk("R12", laser_en, 1'b1, "release after hold");

    // supply loss during transmission
    vcc_good = 1'b0; cyc(1);
    chk("R11", laser_en, 1'b0, "supply loss in run");
    cyc(2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule